// File: doc/BRIEF.md
# Message buffer lock arbiter

This block decides whether the host may take a message buffer of a time-triggered communication controller. The host sends one request per cycle: lock or unlock, a buffer index and a buffer class (transmit, receive or FIFO). The arbiter holds at most one host lock per class. It keeps a commit flag for each buffer, which the host may write only through a lock it holds. It refuses a lock that breaks a protocol rule and returns the outcome one cycle later as an acknowledge pulse with a result code.

Refusals have four causes. The class may already hold a lock. The buffer may be the controller-owned odd half of a double transmit buffer. A committed transmit buffer may be inside the busy window around the slot it is scheduled for. The buffer may already be committed. Each refusal sets a sticky error flag, and the host clears these flags with a write-one-to-clear. While the host holds the lock on a receive buffer, the block also counts the frames that arrive for it. A second arriving frame displaces the older one and sets a frame-lost flag.

Top module: `buf_lock_arb`

## Requirements
- R1: A lock request for a buffer whose commit flag (`commit_o` bit) is 1 is refused with result LOCKERR, and the error bit of the request's class is set.
- R2: A transmit-class lock request for an odd index whose `dbl_i` bit is 1 is refused with LOCKERR and sets error bit 0 (transmit lock error).
- R3: Classes are encoded transmit=0, receive=1, FIFO=2, and code 3 is ignored. Only one lock per class may be held. A lock request to a class that already holds a lock is refused with LOCKERR and sets error bit 0, 1 or 2 for the transmit, receive or FIFO class.
- R4: A transmit lock request is refused with result BUSY and sets error bit 3 when all of the following hold: `sched_vld_i` is 1, `sched_idx_i` equals the requested index, the buffer's commit flag is 1, and the scheduler time is inside the busy window. Refusal causes are checked in this order: class occupied, odd half, busy, committed.
- R5: The busy window covers three stretches. The first is the last GUARD_UT (4) microticks of slot `sched_slot_i`-1, that is `ut_i` >= SLOT_UT-4. The second is the whole of slot `sched_slot_i`. The third is the first 4 microticks of the next slot (`ut_i` < 4). Outside the window, and for an uncommitted scheduled buffer, the busy rule does not refuse.
- R6: While the receive class holds a lock, the second and any later frame arriving at that buffer sets error bit 4 (frame lost). A new receive lock restarts the count. Frames to a buffer the host does not hold set no flag.
- R7: A commit write (`cmt_we_i`) changes `commit_o[cmt_idx_i]` only while some class holds a lock on that index. Otherwise it is ignored.
- R8: Error flags are sticky and clear only where the matching `err_clr_i` bit is 1. A flag set in the same cycle as its clear stays set.
- R9: An unlock request for a buffer its class does not hold changes no lock state. A valid unlock frees the class on the next clock.
- R10: In the cycle after a lock request is sampled, `ack_o` is 1 for one cycle with `res_o` = 1 (GRANT), 2 (LOCKERR) or 3 (BUSY). At all other times `ack_o` is 0 and `res_o` is 0. Unlocks give no acknowledge.
- R11: After reset no lock is held, all commit flags and error flags are 0, and `ack_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request strobe |
| req_unlock_i | input | 1 | 1 = unlock, 0 = lock |
| req_cls_i | input | 2 | Buffer class of request |
| req_idx_i | input | IDX_W | Buffer index of request |
| cmt_we_i | input | 1 | Commit flag write strobe |
| cmt_idx_i | input | IDX_W | Buffer index of commit write |
| cmt_val_i | input | 1 | Commit flag value |
| dbl_i | input | NUM_BUF | Buffer belongs to a double transmit pair |
| sched_vld_i | input | 1 | A transmit buffer is scheduled |
| sched_idx_i | input | IDX_W | Scheduled buffer index |
| sched_slot_i | input | SLOT_W | Slot the buffer is scheduled for |
| slot_i | input | SLOT_W | Current slot number |
| ut_i | input | UT_W | Microtick within the current slot |
| frm_vld_i | input | 1 | Frame arrived for a receive buffer |
| frm_idx_i | input | IDX_W | Index of the receive buffer hit |
| err_clr_i | input | 5 | Write-one-to-clear for error flags |
| ack_o | output | 1 | Lock request outcome valid |
| res_o | output | 2 | Lock result code |
| lock_vld_o | output | 3 | Class holds a lock, per class |
| lock_idx_o | output | 3xIDX_W | Locked buffer index, per class |
| commit_o | output | NUM_BUF | Commit flags |
| err_o | output | 5 | Sticky error flags |

## Verification
The hardest case to reach is the busy window. It needs a committed transmit buffer, which can only be committed through a lock, then released, and the scheduler inputs placed on exact microtick edges on both sides of the slot. The stimulus locks the buffer, commits it, unlocks it, and then probes one microtick inside and one outside each edge of the window. At each probe it expects BUSY or a plain commit refusal. Frame loss is reached in a similar way: the host holds a receive lock, two frames are driven at it, and then the lock is taken again to show that the count restarts.

// File: rtl/buf_lock_pkg.sv
package buf_lock_pkg;
  localparam int NUM_CLS = 3;
  localparam int ERR_W   = 5;
  localparam int E_TX    = 0;
  localparam int E_RX    = 1;
  localparam int E_FIFO  = 2;
  localparam int E_BUSY  = 3;
  localparam int E_LOST  = 4;

  typedef enum logic [1:0] {
    CLS_TX   = 2'd0,
    CLS_RX   = 2'd1,
    CLS_FIFO = 2'd2,
    CLS_NONE = 2'd3
  } buf_cls_e;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_GRANT   = 2'd1,
    RES_LOCKERR = 2'd2,
    RES_BUSY    = 2'd3
  } lock_res_e;
endpackage

// File: rtl/buf_busy_win.sv
module buf_busy_win #(
  parameter int SLOT_W   = 8,
  parameter int UT_W     = 8,
  parameter int SLOT_UT  = 64,
  parameter int GUARD_UT = 4
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [UT_W-1:0]   ut_i,
  input  logic [SLOT_W-1:0] tgt_slot_i,
  output logic              in_win_o
);
  localparam int TAIL = SLOT_UT - GUARD_UT;

  logic [SLOT_W-1:0] prev_s, next_s;
  logic in_tail, in_slot, in_head;

  assign prev_s  = tgt_slot_i - SLOT_W'(1);
  assign next_s  = tgt_slot_i + SLOT_W'(1);
  assign in_tail = (slot_i == prev_s) && (ut_i >= UT_W'(TAIL));
  assign in_slot = (slot_i == tgt_slot_i);
  assign in_head = (slot_i == next_s) && (ut_i < UT_W'(GUARD_UT));
  assign in_win_o = in_tail | in_slot | in_head;
endmodule

// File: rtl/buf_lock_slots.sv
module buf_lock_slots #(
  parameter int NUM_CLS = 3,
  parameter int IDX_W   = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CLS-1:0]             set_i,
  input  logic [NUM_CLS-1:0]             clr_i,
  input  logic [IDX_W-1:0]               idx_i,
  output logic [NUM_CLS-1:0]             vld_o,
  output logic [NUM_CLS-1:0][IDX_W-1:0]  idx_o
);
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[c] <= 1'b0;
        idx_o[c] <= '0;
      end else if (set_i[c]) begin
        vld_o[c] <= 1'b1;
        idx_o[c] <= idx_i;
      end else if (clr_i[c]) begin
        vld_o[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/buf_err_bank.sv
module buf_err_bank #(
  parameter int ERR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ERR_W-1:0] set_i,
  input  logic [ERR_W-1:0] clr_i,
  output logic [ERR_W-1:0] err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= '0;
    else         err_o <= (err_o & ~clr_i) | set_i;  // set wins
  end
endmodule

// File: rtl/buf_lock_arb.sv
module buf_lock_arb
  import buf_lock_pkg::*;
#(
  parameter  int NUM_BUF  = 16,
  parameter  int SLOT_W   = 8,
  parameter  int UT_W     = 8,
  parameter  int SLOT_UT  = 64,
  parameter  int GUARD_UT = 4,
  localparam int IDX_W    = $clog2(NUM_BUF)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  input  logic                          req_unlock_i,
  input  logic [1:0]                    req_cls_i,
  input  logic [IDX_W-1:0]              req_idx_i,
  input  logic                          cmt_we_i,
  input  logic [IDX_W-1:0]              cmt_idx_i,
  input  logic                          cmt_val_i,
  input  logic [NUM_BUF-1:0]            dbl_i,
  input  logic                          sched_vld_i,
  input  logic [IDX_W-1:0]              sched_idx_i,
  input  logic [SLOT_W-1:0]             sched_slot_i,
  input  logic [SLOT_W-1:0]             slot_i,
  input  logic [UT_W-1:0]               ut_i,
  input  logic                          frm_vld_i,
  input  logic [IDX_W-1:0]              frm_idx_i,
  input  logic [4:0]                    err_clr_i,
  output logic                          ack_o,
  output logic [1:0]                    res_o,
  output logic [2:0]                    lock_vld_o,
  output logic [2:0][IDX_W-1:0]         lock_idx_o,
  output logic [NUM_BUF-1:0]            commit_o,
  output logic [4:0]                    err_o
);
  logic [NUM_CLS-1:0] sel, set_lock, clr_lock;
  logic [ERR_W-1:0]   err_set;
  logic               lock_req, unl_req, cls_held, held_match;
  logic               odd_half, in_win, busy_blk, cmt_held, rx_hit;
  logic               pend_q;
  lock_res_e          res_d;

  // one-hot class decode; code 3 selects nothing
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_sel
    assign sel[c] = (req_cls_i == 2'(c));
  end

  assign lock_req = req_valid_i & ~req_unlock_i & (|sel);
  assign unl_req  = req_valid_i &  req_unlock_i & (|sel);
  assign odd_half = dbl_i[req_idx_i] & req_idx_i[0];

  always_comb begin
    cls_held   = 1'b0;
    held_match = 1'b0;
    cmt_held   = 1'b0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (sel[c]) begin
        cls_held   = lock_vld_o[c];
        held_match = lock_vld_o[c] && (lock_idx_o[c] == req_idx_i);
      end
      if (lock_vld_o[c] && (lock_idx_o[c] == cmt_idx_i)) cmt_held = 1'b1;
    end
  end

  buf_busy_win #(
    .SLOT_W(SLOT_W), .UT_W(UT_W), .SLOT_UT(SLOT_UT), .GUARD_UT(GUARD_UT)
  ) u_win (
    .slot_i    (slot_i),
    .ut_i      (ut_i),
    .tgt_slot_i(sched_slot_i),
    .in_win_o  (in_win)
  );

  assign busy_blk = sel[CLS_TX] & sched_vld_i & (sched_idx_i == req_idx_i)
                  & commit_o[req_idx_i] & in_win;

  // refusal priority: class occupied, odd half, busy window, committed
  always_comb begin
    res_d    = RES_NONE;
    set_lock = '0;
    err_set  = '0;
    if (lock_req) begin
      if (cls_held) begin
        res_d = RES_LOCKERR;
        err_set[NUM_CLS-1:0] = sel;
      end else if (sel[CLS_TX] && odd_half) begin
        res_d = RES_LOCKERR;
        err_set[E_TX] = 1'b1;
      end else if (busy_blk) begin
        res_d = RES_BUSY;
        err_set[E_BUSY] = 1'b1;
      end else if (commit_o[req_idx_i]) begin
        res_d = RES_LOCKERR;
        err_set[NUM_CLS-1:0] = sel;
      end else begin
        res_d    = RES_GRANT;
        set_lock = sel;
      end
    end
    err_set[E_LOST] = rx_hit & pend_q;
  end

  assign clr_lock = (unl_req && held_match) ? sel : '0;
  assign rx_hit   = frm_vld_i & lock_vld_o[CLS_RX] & (lock_idx_o[CLS_RX] == frm_idx_i);

  buf_lock_slots #(.NUM_CLS(NUM_CLS), .IDX_W(IDX_W)) u_slots (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_lock),
    .clr_i (clr_lock),
    .idx_i (req_idx_i),
    .vld_o (lock_vld_o),
    .idx_o (lock_idx_o)
  );

  buf_err_bank #(.ERR_W(ERR_W)) u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (err_set),
    .clr_i (err_clr_i),
    .err_o (err_o)
  );

  // pending frame on the host-held receive buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                pend_q <= 1'b0;
    else if (set_lock[CLS_RX] || clr_lock[CLS_RX]) pend_q <= 1'b0;
    else if (rx_hit)                            pend_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   commit_o <= '0;
    else if (cmt_we_i && cmt_held) commit_o[cmt_idx_i] <= cmt_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o <= 1'b0;
      res_o <= RES_NONE;
    end else begin
      ack_o <= lock_req;
      res_o <= res_d;
    end
  end
endmodule

// File: rtl/buf_lock_arb_chk.sv
module buf_lock_arb_chk #(
  parameter int NUM_BUF = 16,
  parameter int IDX_W   = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_unlock_i,
  input logic [1:0]            req_cls_i,
  input logic [IDX_W-1:0]      req_idx_i,
  input logic                  cmt_we_i,
  input logic [IDX_W-1:0]      cmt_idx_i,
  input logic [NUM_BUF-1:0]    dbl_i,
  input logic [4:0]            err_clr_i,
  input logic                  ack_o,
  input logic [1:0]            res_o,
  input logic [2:0]            lock_vld_o,
  input logic [2:0][IDX_W-1:0] lock_idx_o,
  input logic [NUM_BUF-1:0]    commit_o,
  input logic [4:0]            err_o
);
  logic lk, ul, cls_full, ul_own, cmt_own;

  assign lk = req_valid_i && !req_unlock_i && (req_cls_i != 2'd3);
  assign ul = req_valid_i &&  req_unlock_i && (req_cls_i != 2'd3);

  always_comb begin
    cls_full = 1'b0;
    ul_own   = 1'b0;
    cmt_own  = 1'b0;
    for (int c = 0; c < 3; c++) begin
      if (req_cls_i == 2'(c)) begin
        cls_full = lock_vld_o[c];
        ul_own   = lock_vld_o[c] && (lock_idx_o[c] == req_idx_i);
      end
      if (lock_vld_o[c] && (lock_idx_o[c] == cmt_idx_i)) cmt_own = 1'b1;
    end
  end

  a_r1_committed_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk && commit_o[req_idx_i] |=> ack_o && (res_o != 2'd1));

  a_r2_odd_half_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk && (req_cls_i == 2'd0) && dbl_i[req_idx_i] && req_idx_i[0] |=> ack_o && (res_o == 2'd2));

  a_r3_class_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk && cls_full |=> ack_o && (res_o == 2'd2));

  a_r7_commit_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmt_we_i && cmt_own) |=> $stable(commit_o));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(err_o) & ~$past(err_clr_i)) & ~err_o) == 5'd0));

  a_r9_stray_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ul && !ul_own |=> $stable(lock_vld_o));

  a_r10_ack_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o == (res_o != 2'd0));

  a_r10_ack_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk |=> ack_o);
endmodule

bind buf_lock_arb buf_lock_arb_chk #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/buf_lock_arb_tb.sv
`timescale 1ns/1ps
module buf_lock_arb_tb;
  localparam int NB = 16;
  localparam int IW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_unlock_i = 0;
  logic [1:0] req_cls_i = 0;
  logic [IW-1:0] req_idx_i = 0;
  logic cmt_we_i = 0, cmt_val_i = 0;
  logic [IW-1:0] cmt_idx_i = 0;
  logic [NB-1:0] dbl_i = 16'h0030;
  logic sched_vld_i = 0;
  logic [IW-1:0] sched_idx_i = 0;
  logic [7:0] sched_slot_i = 0, slot_i = 0, ut_i = 0;
  logic frm_vld_i = 0;
  logic [IW-1:0] frm_idx_i = 0;
  logic [4:0] err_clr_i = 0;
  logic ack_o;
  logic [1:0] res_o;
  logic [2:0] lock_vld_o;
  logic [2:0][IW-1:0] lock_idx_o;
  logic [NB-1:0] commit_o;
  logic [4:0] err_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  buf_lock_arb u_dut (.*);

  typedef struct packed {
    logic [1:0] op;   // 0 lock, 1 unlock, 2 clear all errors
    logic [1:0] cls;
    logic [3:0] idx;
    logic       ack;
    logic [1:0] res;
    logic [4:0] err;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{2'd0, 2'd0, 4'd2,  1'b1, 2'd1, 5'h00},
    '{2'd0, 2'd0, 4'd3,  1'b1, 2'd2, 5'h01},
    '{2'd0, 2'd1, 4'd7,  1'b1, 2'd1, 5'h01},
    '{2'd0, 2'd1, 4'd8,  1'b1, 2'd2, 5'h03},
    '{2'd0, 2'd2, 4'd10, 1'b1, 2'd1, 5'h03},
    '{2'd0, 2'd2, 4'd11, 1'b1, 2'd2, 5'h07},
    '{2'd2, 2'd0, 4'd0,  1'b0, 2'd0, 5'h00},
    '{2'd1, 2'd0, 4'd3,  1'b0, 2'd0, 5'h00},
    '{2'd0, 2'd0, 4'd4,  1'b1, 2'd2, 5'h01},
    '{2'd1, 2'd0, 4'd2,  1'b0, 2'd0, 5'h01},
    '{2'd2, 2'd0, 4'd0,  1'b0, 2'd0, 5'h00},
    '{2'd0, 2'd0, 4'd5,  1'b1, 2'd2, 5'h01},
    '{2'd0, 2'd0, 4'd4,  1'b1, 2'd1, 5'h01}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // drive at a negedge, release at the next; outputs then hold the registered result
  task automatic req(input logic unl, input logic [1:0] cls, input logic [IW-1:0] idx);
    req_valid_i = 1; req_unlock_i = unl; req_cls_i = cls; req_idx_i = idx;
    @(negedge clk_i);
    req_valid_i = 0; req_unlock_i = 0;
  endtask

  task automatic clr(input logic [4:0] m);
    err_clr_i = m;
    @(negedge clk_i);
    err_clr_i = 0;
  endtask

  task automatic cmt(input logic [IW-1:0] idx, input logic v);
    cmt_we_i = 1; cmt_idx_i = idx; cmt_val_i = v;
    @(negedge clk_i);
    cmt_we_i = 0;
  endtask

  task automatic frm(input logic [IW-1:0] idx);
    frm_vld_i = 1; frm_idx_i = idx;
    @(negedge clk_i);
    frm_vld_i = 0;
  endtask

  task automatic busy_probe(input logic [7:0] s, input logic [7:0] u,
                            input logic [1:0] exp_res, input string rq);
    slot_i = s; ut_i = u;
    req(1'b0, 2'd0, 4'd6);
    chk(rq, {30'd0, res_o}, {30'd0, exp_res});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11 locks", {29'd0, lock_vld_o}, 32'd0);
    chk("R11 err", {27'd0, err_o}, 32'd0);
    chk("R11 ack", {31'd0, ack_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk_i);

    // table walk: class limits, stray unlock, odd half
    for (int i = 0; i < 13; i++) begin
      case (VEC[i].op)
        2'd0:    req(1'b0, VEC[i].cls, VEC[i].idx);
        2'd1:    req(1'b1, VEC[i].cls, VEC[i].idx);
        default: clr(5'h1f);
      endcase
      chk($sformatf("R10 ack v%0d", i), {31'd0, ack_o}, {31'd0, VEC[i].ack});
      chk($sformatf("R3/R2 res v%0d", i), {30'd0, res_o}, {30'd0, VEC[i].res});
      chk($sformatf("R3/R2/R8 err v%0d", i), {27'd0, err_o}, {27'd0, VEC[i].err});
      if (VEC[i].op == 2'd1 && VEC[i].idx == 4'd3)
        chk("R9 stray unlock keeps tx lock", {31'd0, lock_vld_o[0]}, 32'd1);
    end
    chk("R3 tx lock idx", {28'd0, lock_idx_o[0]}, 32'd4);
    @(negedge clk_i);
    chk("R10 ack one cycle", {31'd0, ack_o}, 32'd0);

    // R7 commit only through a held lock
    clr(5'h1f);
    cmt(4'd6, 1'b1);
    chk("R7 commit without lock ignored", {16'd0, commit_o}, 32'd0);
    cmt(4'd4, 1'b1);
    chk("R7 commit with lock", {16'd0, commit_o}, 32'h10);
    req(1'b1, 2'd0, 4'd4);
    chk("R9 unlock frees", {31'd0, lock_vld_o[0]}, 32'd0);
    req(1'b0, 2'd0, 4'd4);
    chk("R1 committed refused", {30'd0, res_o}, 32'd2);
    chk("R1 tx error", {27'd0, err_o}, 32'h01);

    // commit buffer 6 then release it for the busy-window probes
    req(1'b0, 2'd0, 4'd6);
    chk("R9 relock after unlock", {30'd0, res_o}, 32'd1);
    cmt(4'd6, 1'b1);
    req(1'b1, 2'd0, 4'd6);
    clr(5'h1f);
    sched_vld_i = 1; sched_idx_i = 4'd6; sched_slot_i = 8'd10;
    busy_probe(8'd9,  8'd59, 2'd2, "R5 before window");
    busy_probe(8'd9,  8'd60, 2'd3, "R4 window opens");
    chk("R4 busy flag", {27'd0, err_o}, 32'h09);
    busy_probe(8'd10, 8'd30, 2'd3, "R4 inside slot");
    busy_probe(8'd11, 8'd3,  2'd3, "R4 window tail");
    busy_probe(8'd11, 8'd4,  2'd2, "R5 after window");
    chk("R4 no lock while busy", {31'd0, lock_vld_o[0]}, 32'd0);
    sched_idx_i = 4'd9; slot_i = 8'd10;
    req(1'b0, 2'd0, 4'd9);
    chk("R5 uncommitted scheduled grants", {30'd0, res_o}, 32'd1);
    req(1'b1, 2'd0, 4'd9);
    sched_vld_i = 0;

    // R6 frame loss on host-held receive buffer 7
    clr(5'h1f);
    frm(4'd7);
    chk("R6 first frame no loss", {27'd0, err_o}, 32'd0);
    frm(4'd7);
    chk("R6 second frame lost", {27'd0, err_o}, 32'h10);
    clr(5'h1f);
    frm(4'd8); frm(4'd8);
    chk("R6 unheld buffer no loss", {27'd0, err_o}, 32'd0);
    req(1'b1, 2'd1, 4'd7);
    req(1'b0, 2'd1, 4'd7);
    frm(4'd7);
    chk("R6 relock restarts count", {27'd0, err_o}, 32'd0);

    // R8 partial clear and set-over-clear
    frm(4'd7);
    req(1'b0, 2'd0, 4'd9);
    req(1'b0, 2'd0, 4'd2);
    chk("R8 two flags", {27'd0, err_o}, 32'h11);
    clr(5'h10);
    chk("R8 partial clear", {27'd0, err_o}, 32'h01);
    err_clr_i = 5'h01; req_valid_i = 1; req_cls_i = 2'd0; req_idx_i = 4'd3;
    @(negedge clk_i);
    err_clr_i = 0; req_valid_i = 0;
    chk("R8 set wins over clear", {27'd0, err_o}, 32'h01);

    // R11 mid-run reset
    rst_ni = 0;
    @(negedge clk_i);
    chk("R11 reset locks", {29'd0, lock_vld_o}, 32'd0);
    chk("R11 reset commits", {16'd0, commit_o}, 32'd0);
    chk("R11 reset errors", {27'd0, err_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk_i);
    req(1'b0, 2'd3, 4'd1);
    chk("R3 class code 3 ignored", {31'd0, ack_o}, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule